// File: doc/BRIEF.md
# ROM Search Triplet Sequencer

This block carries out a single decision step of the binary identity search on a single-wire bus. It drives a bit-slot engine through a request/acknowledge pair and never handles slot timing itself. When `start` is seen while idle, it captures the preferred branch (`pref_dir`). It then asks for two read slots, which are write-1 slots whose sampled level is returned. The first read gives the identity bit and the second gives its complement.

From those two values the block picks a branch and asks for one more slot that writes the chosen bit onto the wire. If both reads come back high, no device answered consistently. In that case the step stops at once and skips the write slot. The result comes out as a packed 3-bit status word together with a one-cycle `done` pulse.

A search controller runs this step once per identity bit position. It keeps its own record of discrepancy positions and sets `pref_dir` for each step.

Top module: `rom_search_step`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `slot_req` and `status` are all 0.
- R2: A `start` seen while idle makes `busy` and a one-cycle `slot_req` with `slot_wbit`=1 appear one cycle later. That slot reads the identity bit. The cycle after its `slot_ack`, a second one-cycle `slot_req` with `slot_wbit`=1 reads the complement bit.
- R3: When both reads return 1, the cycle after the second acknowledge shows `done`=1 and `status`=3'b011, and no third slot is ever requested.
- R4: When both reads return 0, the branch is `pref_dir`. The third slot writes `slot_wbit`=`pref_dir`, and `status` is 3'b100 for `pref_dir`=1 or 3'b000 for `pref_dir`=0.
- R5: When exactly one read returns 1, the branch is the identity bit. The third slot writes that bit, and `status` is 3'b101 for identity 1 / complement 0, or 3'b010 for identity 0 / complement 1.
- R6: Status field positions: bit 0 holds the identity bit read, bit 1 the complement bit read, and bit 2 the branch taken (0 on the both-ones error).
- R7: `done` is a one-cycle pulse. It rises in the cycle after the acknowledge of the step's last slot, and `busy` is 0 in that cycle.
- R8: `status` changes only in the cycle `done` is high. It keeps its last value across idle time and through the following step until that step completes.
- R9: A `start` that arrives while busy has no effect. No extra slot is requested, and the step keeps the `pref_dir` captured at its own start.
- R10: A `slot_ack` while no slot is outstanding has no effect. This covers acks while idle and acks in the same cycle as `slot_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one search step (taken only when idle) |
| pref_dir | input | 1 | Branch to follow when both reads are 0 |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {branch taken, complement bit, identity bit} |
| slot_req | output | 1 | One-cycle request for a bit slot |
| slot_wbit | output | 1 | Bit to drive in the requested slot (1 = read slot) |
| slot_ack | input | 1 | Slot engine finished the slot |
| slot_rbit | input | 1 | Level sampled during the acknowledged slot |

## Verification
Every result is due a fixed number of registers after its cause. A slot request shows up one cycle after the `start` or acknowledge that triggers it. `done` and the new `status` show up one cycle after the final acknowledge. The bench drives inputs on falling edges and samples exactly one falling edge after the rising edge that consumes them. Whenever an output is expected high, the next falling edge is also checked to see that it has dropped. Slot latencies vary between steps, so these checks follow the acknowledge rather than a fixed cycle count from `start`.

// File: rtl/rom_search_step_pkg.sv
package rom_search_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID   = 2'd1,
    ST_CMP  = 2'd2,
    ST_DIR  = 2'd3
  } step_state_e;

  // Field order is behaviour: bit0 identity, bit1 complement, bit2 branch.
  typedef struct packed {
    logic taken;
    logic cmp;
    logic id;
  } step_stat_t;

  localparam int STAT_W = $bits(step_stat_t);

endpackage

// File: rtl/rom_search_decide.sv
module rom_search_decide
  import rom_search_step_pkg::*;
(
  input  logic       id_bit,
  input  logic       cmp_bit,
  input  logic       pref_dir,
  output logic       dir,
  output logic       abort,
  output step_stat_t stat
);

  always_comb begin
    abort = id_bit & cmp_bit;
    if (id_bit ^ cmp_bit) dir = id_bit;
    else                  dir = pref_dir;
    stat.id    = id_bit;
    stat.cmp   = cmp_bit;
    stat.taken = abort ? 1'b0 : dir;
  end

endmodule

// File: rtl/rom_search_fsm.sv
module rom_search_fsm
  import rom_search_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pref_dir,
  input  logic              slot_ack,
  input  logic              slot_rbit,
  input  logic              dec_dir,
  input  logic              dec_abort,
  input  step_stat_t        dec_stat,
  output logic              id_q,
  output logic              pref_q,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] status,
  output logic              slot_req,
  output logic              slot_wbit
);

  step_state_e state;
  step_stat_t  pend;
  logic        ack_ok;

  // An acknowledge counts only once the request pulse has been seen.
  assign ack_ok = slot_ack && !slot_req;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      id_q      <= 1'b0;
      pref_q    <= 1'b0;
      done      <= 1'b0;
      status    <= '0;
      slot_req  <= 1'b0;
      slot_wbit <= 1'b0;
    end else begin
      slot_req <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pref_q    <= pref_dir;
            slot_req  <= 1'b1;
            slot_wbit <= 1'b1;
            state     <= ST_ID;
          end
        end
        ST_ID: begin
          if (ack_ok) begin
            id_q      <= slot_rbit;
            slot_req  <= 1'b1;
            slot_wbit <= 1'b1;
            state     <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (ack_ok) begin
            pend <= dec_stat;
            if (dec_abort) begin
              status <= dec_stat;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              slot_req  <= 1'b1;
              slot_wbit <= dec_dir;
              state     <= ST_DIR;
            end
          end
        end
        ST_DIR: begin
          if (ack_ok) begin
            status <= pend;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import rom_search_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pref_dir,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] status,
  output logic              slot_req,
  output logic              slot_wbit,
  input  logic              slot_ack,
  input  logic              slot_rbit
);

  logic       id_q;
  logic       pref_q;
  logic       dec_dir;
  logic       dec_abort;
  step_stat_t dec_stat;

  // The complement bit is decided on the cycle its acknowledge arrives.
  rom_search_decide u_decide (
    .id_bit   (id_q),
    .cmp_bit  (slot_rbit),
    .pref_dir (pref_q),
    .dir      (dec_dir),
    .abort    (dec_abort),
    .stat     (dec_stat)
  );

  rom_search_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pref_dir  (pref_dir),
    .slot_ack  (slot_ack),
    .slot_rbit (slot_rbit),
    .dec_dir   (dec_dir),
    .dec_abort (dec_abort),
    .dec_stat  (dec_stat),
    .id_q      (id_q),
    .pref_q    (pref_q),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .slot_req  (slot_req),
    .slot_wbit (slot_wbit)
  );

endmodule

// File: rtl/rom_search_step_sva.sv
module rom_search_step_sva (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       slot_req,
  input logic       slot_wbit,
  input logic       slot_ack
);

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    slot_req |=> !slot_req);

  p_start_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && slot_req && slot_wbit));

  p_err_code_r3: assert property (@(posedge clk) disable iff (rst)
    (done && status[0] && status[1]) |-> !status[2]);

  p_forced_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (done && (status[0] != status[1])) |-> (status[2] == status[0]));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !slot_req));

  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(status));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !slot_ack) |=> !slot_req);

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && slot_ack) |=> (!slot_req && !busy && !done));

endmodule

bind rom_search_step rom_search_step_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .slot_req  (slot_req),
  .slot_wbit (slot_wbit),
  .slot_ack  (slot_ack)
);

// File: tb/sim_rom_search_step.sv
module sim_rom_search_step;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       pref_dir = 1'b0;
  logic       busy, done, slot_req, slot_wbit;
  logic [2:0] status;
  logic       slot_ack = 1'b0;
  logic       slot_rbit = 1'b0;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  logic [2:0] prev_stat = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_search_step u0 (
    .clk(clk), .rst(rst), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .status(status),
    .slot_req(slot_req), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Entered at the falling edge where the request should be visible.
  task automatic serve(input logic rbit, input logic exp_w, input int lat,
                       input string tag);
    chk({tag, " slot_req"}, int'(slot_req), 1);
    chk({tag, " slot_wbit"}, int'(slot_wbit), int'(exp_w));
    @(negedge clk);
    chk("R2 slot_req one-cycle", int'(slot_req), 0);
    repeat (lat) @(negedge clk);
    slot_ack  = 1'b1;
    slot_rbit = rbit;
    @(negedge clk);
    slot_ack  = 1'b0;
    slot_rbit = 1'b0;
  endtask

  task automatic run_step(input logic pref, input logic id, input logic cmp,
                          input int lat, input string tag);
    logic       err;
    logic       dir;
    logic [2:0] exp_stat;
    err = id & cmp;
    dir = (id ^ cmp) ? id : pref;
    exp_stat = {(err ? 1'b0 : dir), cmp, id};
    start = 1'b1;
    pref_dir = pref;
    @(negedge clk);
    start = 1'b0;
    pref_dir = ~pref;
    chk("R2 busy after start", int'(busy), 1);
    chk("R8 status held into new step", int'(status), int'(prev_stat));
    serve(id, 1'b1, lat, "R2 id slot");
    serve(cmp, 1'b1, lat, "R2 cmp slot");
    if (err) begin
      chk("R3 done after both-ones", int'(done), 1);
      chk("R3 no write slot", int'(slot_req), 0);
    end else begin
      chk("R7 done not before write", int'(done), 0);
      chk("R8 status held before done", int'(status), int'(prev_stat));
      serve(1'b0, dir, lat, {tag, " write slot"});
      chk("R7 done after write ack", int'(done), 1);
    end
    chk({tag, " status"}, int'(status), int'(exp_stat));
    chk("R6 status bit0 is id", int'(status[0]), int'(id));
    chk("R6 status bit1 is cmp", int'(status[1]), int'(cmp));
    chk("R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R7 done one-cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R3 no further slot", int'(slot_req), 0);
    chk("R8 status held idle", int'(status), int'(exp_stat));
    prev_stat = exp_stat;
  endtask

  task automatic busy_start_test();
    start = 1'b1;
    pref_dir = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 id slot req", int'(slot_req), 1);
    @(negedge clk);
    start = 1'b1;
    pref_dir = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no slot from busy start", int'(slot_req), 0);
    slot_ack = 1'b1;
    slot_rbit = 1'b0;
    @(negedge clk);
    slot_ack = 1'b0;
    serve(1'b0, 1'b1, 1, "R9 cmp slot");
    serve(1'b0, 1'b0, 1, "R9 write keeps pref 0");
    chk("R9 status", int'(status), 0);
    chk("R9 done", int'(done), 1);
    repeat (3) @(negedge clk);
    chk("R9 no extra step", int'(busy), 0);
    prev_stat = 3'b000;
  endtask

  task automatic stray_ack_test();
    slot_ack = 1'b1;
    slot_rbit = 1'b1;
    @(negedge clk);
    slot_ack = 1'b0;
    slot_rbit = 1'b0;
    chk("R10 idle ack no req", int'(slot_req), 0);
    chk("R10 idle ack no busy", int'(busy), 0);
    chk("R10 idle ack no done", int'(done), 0);
    chk("R10 idle ack status", int'(status), int'(prev_stat));
    // Ack coincident with the request pulse must not count.
    start = 1'b1;
    pref_dir = 1'b1;
    @(negedge clk);
    start = 1'b0;
    slot_ack = 1'b1;
    slot_rbit = 1'b1;
    @(negedge clk);
    slot_ack = 1'b0;
    slot_rbit = 1'b0;
    chk("R10 early ack ignored", int'(slot_req), 0);
    chk("R10 still busy", int'(busy), 1);
    slot_ack = 1'b1;
    slot_rbit = 1'b0;
    @(negedge clk);
    slot_ack = 1'b0;
    serve(1'b0, 1'b1, 0, "R10 cmp slot");
    serve(1'b0, 1'b1, 0, "R10 write slot");
    chk("R10 status", int'(status), 3'b100);
    prev_stat = 3'b100;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 slot_req in reset", int'(slot_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 status after reset", int'(status), 0);
    run_step(1'b1, 1'b0, 1'b0, 1, "R4");
    run_step(1'b0, 1'b0, 1'b0, 3, "R4");
    run_step(1'b0, 1'b1, 1'b0, 2, "R5");
    run_step(1'b1, 1'b0, 1'b1, 0, "R5");
    run_step(1'b1, 1'b1, 1'b1, 2, "R3");
    run_step(1'b0, 1'b1, 1'b1, 0, "R3");
    busy_start_test();
    stray_ack_test();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule